// File: doc/BRIEF.md
# Directory-Based MESI Coherence Controller

This block is the coherence directory for one shared second-level slice. For every line it keeps two separate records. The first is the slice's own copy state (not fetched, clean or dirty) together with the line data. The second is the directory view: I, S, E or M, one owner id and a sharer bit-vector. The slice holds every line of its address range, so lines are never replaced. Private caches send loads and stores on a request channel. The controller answers on a forward channel with memory reads, downgrades and invalidations. It collects memory data, downgrade acknowledgements, writeback guards and writebacks on a response channel, and finally grants the line to the requester with a one-cycle data acknowledgement. Private caches never talk to each other; every exchange goes through this block.

One transaction is in flight at a time. The FSM states are ST_IDLE (accept a request or absorb a stray writeback), ST_MEMREQ and ST_MEMWAIT (fetch from memory), ST_DGREQ and ST_DGWAIT (downgrade the current owner), ST_INVREQ and ST_INVWAIT (invalidate sharers one by one), and ST_GRANT (send the data acknowledgement). The transitions are as follows. ST_IDLE goes to ST_MEMREQ, ST_DGREQ, ST_INVREQ or ST_GRANT depending on the line record. Each *REQ state goes to its *WAIT state when the forward is accepted. ST_MEMWAIT and ST_DGWAIT go to ST_GRANT when the completing response arrives. ST_INVWAIT goes back to ST_INVREQ while sharers remain, otherwise to ST_GRANT. ST_GRANT returns to ST_IDLE.

The response channel has no ready signal and is consumed every cycle. Clean private copies may disappear silently, so owner and sharer entries can be stale. A downgrade answered without data falls back on the slice copy.

Top module: `mesi_dir_ctrl`

## Requirements
- R1: After reset, req_ready is 1 and fwd_valid and ack_valid are 0. Every line is not fetched and has directory state I.
- R2: A load or store to a line that is not fetched and has no holder sends one forward of type 0 (memory read) with fwd_dest 0. The memory-data response (rsp_type 0) then produces an acknowledgement carrying that data, with state E (2) for a load or M (3) for a store.
- R3: A load or store to a fetched line whose directory state is I is granted from the slice copy with no forward: E (2) for a load, M (3) for a store.
- R4: A load to a line in S is granted S (1) at once with no forward, and the requester is added as a sharer.
- R5: A load to a line held in E or M by another cache sends a read downgrade (fwd_type 1) to that owner. The acknowledgement (rsp_type 1) completes it. The grant is S with the returned data if rsp_dirty is 1, else with the slice copy. Both caches are then sharers.
- R6: A store to a line held in E or M by another cache sends a write downgrade (fwd_type 2) to that owner. After its acknowledgement the requester is granted M (3) with the returned or slice data and becomes sole owner.
- R7: A store to a line in S sends one invalidation (fwd_type 3) to each other sharer, lowest id first and one at a time, each waiting for its acknowledgement. After the last one the requester is granted M.
- R8: A request from the recorded owner is granted with no forward: a load in the recorded state (E or M), a store in M.
- R9: While a transaction is pending, req_ready is 0 and no acknowledgement appears before the final completing response. Each acknowledgement lasts one cycle.
- R10: A writeback (rsp_type 3) from the recorded E/M owner of a line is accepted at any time, even while another line is pending. It stores the data and sets the directory state to I. A writeback from a cache that is not the owner changes nothing.
- R11: A writeback guard (rsp_type 2) from the cache being downgraded does not complete the transaction. The following writeback completes it and its data is granted.
- R12: While fwd_valid is 1 and fwd_ready is 0, the forward type, destination and address stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle |
| req_op | input | 1 | 0 load, 1 store |
| req_src | input | ID_W | Requesting cache id |
| req_addr | input | IDX_W | Line index |
| fwd_valid | output | 1 | Forward message present |
| fwd_ready | input | 1 | Forward accepted |
| fwd_type | output | 2 | 0 memory read, 1 read downgrade, 2 write downgrade, 3 invalidate |
| fwd_dest | output | ID_W | Target cache (0 for memory reads) |
| fwd_addr | output | IDX_W | Line index |
| rsp_valid | input | 1 | Response present (never stalled) |
| rsp_type | input | 2 | 0 memory data, 1 downgrade ack, 2 writeback guard, 3 writeback |
| rsp_src | input | ID_W | Responding cache id |
| rsp_addr | input | IDX_W | Line index |
| rsp_dirty | input | 1 | Downgrade ack carries modified data |
| rsp_data | input | DATA_W | Response data |
| ack_valid | output | 1 | Data acknowledgement present |
| ack_dest | output | ID_W | Requester being granted |
| ack_state | output | 2 | Granted state: 1 S, 2 E, 3 M |
| ack_data | output | DATA_W | Line data |

## Verification
A wrong directory record stays hidden until the next request to that line. It then shows up as the wrong forward, or a missing one, in the cycle after acceptance: a memory read where the slice copy should serve, a downgrade to the wrong owner, or an invalidation to the requester. A wrong slice copy appears only in ack_data at the grant. For that reason the stimulus revisits the same few lines repeatedly, and each request's forward count, first target and grant are compared against the history built up by earlier requests and writebacks.

// File: rtl/mesi_dir_pkg.sv
package mesi_dir_pkg;

    typedef enum logic [1:0] {MS_I = 2'd0, MS_S = 2'd1, MS_E = 2'd2, MS_M = 2'd3} mesi_e;
    typedef enum logic [1:0] {L2_NONE = 2'd0, L2_CLEAN = 2'd1, L2_DIRTY = 2'd2} l2_e;
    typedef enum logic [1:0] {FW_MEMRD = 2'd0, FW_DGRD = 2'd1, FW_DGWR = 2'd2, FW_INV = 2'd3} fwd_e;
    typedef enum logic [1:0] {RS_MEMDATA = 2'd0, RS_DGACK = 2'd1, RS_WBGUARD = 2'd2, RS_WB = 2'd3} rsp_e;
    typedef enum logic [2:0] {
        ST_IDLE, ST_MEMREQ, ST_MEMWAIT, ST_DGREQ, ST_DGWAIT, ST_INVREQ, ST_INVWAIT, ST_GRANT
    } fsm_e;

endpackage

// File: rtl/mesi_dir_store.sv
module mesi_dir_store
    import mesi_dir_pkg::*;
#(
    parameter int NLINE  = 8,
    parameter int NCACHE = 4,
    parameter int DATA_W = 16,
    localparam int IDX_W = $clog2(NLINE),
    localparam int ID_W  = $clog2(NCACHE)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  ra_idx,
    output l2_e               ra_l2,
    output mesi_e             ra_dir,
    output logic [ID_W-1:0]   ra_own,
    output logic [NCACHE-1:0] ra_shr,
    output logic [DATA_W-1:0] ra_data,
    input  logic [IDX_W-1:0]  rb_idx,
    output mesi_e             rb_dir,
    output logic [ID_W-1:0]   rb_own,
    input  logic              we,
    input  logic [IDX_W-1:0]  w_idx,
    input  l2_e               w_l2,
    input  mesi_e             w_dir,
    input  logic [ID_W-1:0]   w_own,
    input  logic [NCACHE-1:0] w_shr,
    input  logic [DATA_W-1:0] w_data
);

    l2_e               l2_q   [NLINE];
    mesi_e             dir_q  [NLINE];
    logic [ID_W-1:0]   own_q  [NLINE];
    logic [NCACHE-1:0] shr_q  [NLINE];
    logic [DATA_W-1:0] data_q [NLINE];

    for (genvar g = 0; g < NLINE; g++) begin : g_line
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                l2_q[g]   <= L2_NONE;
                dir_q[g]  <= MS_I;
                own_q[g]  <= '0;
                shr_q[g]  <= '0;
                data_q[g] <= '0;
            end else if (we && w_idx == IDX_W'(g)) begin
                l2_q[g]   <= w_l2;
                dir_q[g]  <= w_dir;
                own_q[g]  <= w_own;
                shr_q[g]  <= w_shr;
                data_q[g] <= w_data;
            end
        end
    end

    assign ra_l2   = l2_q[ra_idx];
    assign ra_dir  = dir_q[ra_idx];
    assign ra_own  = own_q[ra_idx];
    assign ra_shr  = shr_q[ra_idx];
    assign ra_data = data_q[ra_idx];
    assign rb_dir  = dir_q[rb_idx];
    assign rb_own  = own_q[rb_idx];

    AST_OWNED_NO_SHARERS: assert property (@(posedge clk) disable iff (!rst_n)
        we && (w_dir == MS_E || w_dir == MS_M) |-> w_shr == '0); // R6
    AST_SHARED_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        we && w_dir == MS_S |-> w_shr != '0); // R5
    AST_HELD_HAS_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        we && w_dir != MS_I |-> w_l2 != L2_NONE); // R2

endmodule

// File: rtl/mesi_dir_pick.sv
module mesi_dir_pick #(
    parameter int N = 4,
    localparam int W = $clog2(N)
) (
    input  logic [N-1:0] mask,
    output logic [W-1:0] idx,
    output logic         found
);

    always_comb begin
        idx   = '0;
        found = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (mask[i]) begin
                idx   = W'(i);
                found = 1'b1;
            end
        end
    end

endmodule

// File: rtl/mesi_dir_fsm.sv
module mesi_dir_fsm
    import mesi_dir_pkg::*;
#(
    parameter int NLINE  = 8,
    parameter int NCACHE = 4,
    parameter int DATA_W = 16,
    localparam int IDX_W = $clog2(NLINE),
    localparam int ID_W  = $clog2(NCACHE)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_op,
    input  logic [ID_W-1:0]   req_src,
    input  logic [IDX_W-1:0]  req_addr,
    output logic              fwd_valid,
    input  logic              fwd_ready,
    output fwd_e              fwd_type,
    output logic [ID_W-1:0]   fwd_dest,
    output logic [IDX_W-1:0]  fwd_addr,
    input  logic              rsp_valid,
    input  rsp_e              rsp_type,
    input  logic [ID_W-1:0]   rsp_src,
    input  logic [IDX_W-1:0]  rsp_addr,
    input  logic              rsp_dirty,
    input  logic [DATA_W-1:0] rsp_data,
    output logic              ack_valid,
    output logic [ID_W-1:0]   ack_dest,
    output mesi_e             ack_state,
    output logic [DATA_W-1:0] ack_data,
    output logic [IDX_W-1:0]  ra_idx,
    input  l2_e               ra_l2,
    input  mesi_e             ra_dir,
    input  logic [ID_W-1:0]   ra_own,
    input  logic [NCACHE-1:0] ra_shr,
    input  logic [DATA_W-1:0] ra_data,
    output logic [IDX_W-1:0]  rb_idx,
    input  mesi_e             rb_dir,
    input  logic [ID_W-1:0]   rb_own,
    output logic              we,
    output logic [IDX_W-1:0]  w_idx,
    output l2_e               w_l2,
    output mesi_e             w_dir,
    output logic [ID_W-1:0]   w_own,
    output logic [NCACHE-1:0] w_shr,
    output logic [DATA_W-1:0] w_data
);

    function automatic logic [NCACHE-1:0] bit_of(input logic [ID_W-1:0] id);
        return NCACHE'(1) << id;
    endfunction

    fsm_e              state_q, state_d;
    logic              t_op_q, t_op_d;
    logic [ID_W-1:0]   t_src_q, t_src_d;
    logic [IDX_W-1:0]  t_idx_q, t_idx_d;
    logic [ID_W-1:0]   t_tgt_q, t_tgt_d;
    logic [NCACHE-1:0] t_rem_q, t_rem_d;
    mesi_e             t_gst_q, t_gst_d;

    logic [NCACHE-1:0] pick_in;
    logic [ID_W-1:0]   pick_idx;
    logic              pick_found;
    logic              accept, txn_rsp, stray_wb, has_data;

    mesi_dir_pick #(.N(NCACHE)) u_pick (
        .mask (pick_in),
        .idx  (pick_idx),
        .found(pick_found)
    );

    assign pick_in = (state_q == ST_IDLE) ? (ra_shr & ~bit_of(req_src))
                                          : (t_rem_q & ~bit_of(t_tgt_q));
    assign accept  = req_valid && req_ready;

    assign txn_rsp = rsp_valid && rsp_addr == t_idx_q && (
        (state_q == ST_MEMWAIT && rsp_type == RS_MEMDATA) ||
        (state_q == ST_DGWAIT  && rsp_src == t_tgt_q && rsp_type != RS_MEMDATA) ||
        (state_q == ST_INVWAIT && rsp_src == t_tgt_q && rsp_type == RS_DGACK));

    assign stray_wb = rsp_valid && !txn_rsp && rsp_type == RS_WB &&
                      (rb_dir == MS_E || rb_dir == MS_M) && rb_own == rsp_src;
    assign has_data = rsp_type == RS_WB || rsp_dirty;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            t_op_q  <= 1'b0;
            t_src_q <= '0;
            t_idx_q <= '0;
            t_tgt_q <= '0;
            t_rem_q <= '0;
            t_gst_q <= MS_I;
        end else begin
            state_q <= state_d;
            t_op_q  <= t_op_d;
            t_src_q <= t_src_d;
            t_idx_q <= t_idx_d;
            t_tgt_q <= t_tgt_d;
            t_rem_q <= t_rem_d;
            t_gst_q <= t_gst_d;
        end
    end

    // transitions and line updates
    always_comb begin
        state_d = state_q;
        t_op_d  = t_op_q;
        t_src_d = t_src_q;
        t_idx_d = t_idx_q;
        t_tgt_d = t_tgt_q;
        t_rem_d = t_rem_q;
        t_gst_d = t_gst_q;
        we      = 1'b0;
        w_idx   = ra_idx;
        w_l2    = ra_l2;
        w_dir   = ra_dir;
        w_own   = ra_own;
        w_shr   = ra_shr;
        w_data  = ra_data;

        if (stray_wb) begin
            we     = 1'b1;
            w_idx  = rsp_addr;
            w_l2   = L2_DIRTY;
            w_dir  = MS_I;
            w_own  = '0;
            w_shr  = '0;
            w_data = rsp_data;
        end

        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    t_op_d  = req_op;
                    t_src_d = req_src;
                    t_idx_d = req_addr;
                    unique case (ra_dir)
                        MS_I: begin
                            if (ra_l2 == L2_NONE) begin
                                state_d = ST_MEMREQ;
                            end else begin
                                we      = 1'b1;
                                w_dir   = req_op ? MS_M : MS_E;
                                w_own   = req_src;
                                w_shr   = '0;
                                t_gst_d = req_op ? MS_M : MS_E;
                                state_d = ST_GRANT;
                            end
                        end
                        MS_S: begin
                            if (!req_op) begin
                                we      = 1'b1;
                                w_shr   = ra_shr | bit_of(req_src);
                                t_gst_d = MS_S;
                                state_d = ST_GRANT;
                            end else if (!pick_found) begin
                                we      = 1'b1;
                                w_dir   = MS_M;
                                w_own   = req_src;
                                w_shr   = '0;
                                t_gst_d = MS_M;
                                state_d = ST_GRANT;
                            end else begin
                                t_rem_d = pick_in;
                                t_tgt_d = pick_idx;
                                state_d = ST_INVREQ;
                            end
                        end
                        MS_E, MS_M: begin
                            if (ra_own == req_src) begin
                                if (req_op) begin
                                    we      = 1'b1;
                                    w_dir   = MS_M;
                                    t_gst_d = MS_M;
                                end else begin
                                    t_gst_d = ra_dir;
                                end
                                state_d = ST_GRANT;
                            end else begin
                                t_tgt_d = ra_own;
                                state_d = ST_DGREQ;
                            end
                        end
                        default: state_d = ST_IDLE;
                    endcase
                end
            end
            ST_MEMREQ:  if (fwd_ready) state_d = ST_MEMWAIT;
            ST_DGREQ:   if (fwd_ready) state_d = ST_DGWAIT;
            ST_INVREQ:  if (fwd_ready) state_d = ST_INVWAIT;
            ST_MEMWAIT: begin
                if (txn_rsp) begin
                    we      = 1'b1;
                    w_l2    = L2_CLEAN;
                    w_data  = rsp_data;
                    w_dir   = t_op_q ? MS_M : MS_E;
                    w_own   = t_src_q;
                    w_shr   = '0;
                    t_gst_d = t_op_q ? MS_M : MS_E;
                    state_d = ST_GRANT;
                end
            end
            ST_DGWAIT: begin
                if (txn_rsp && rsp_type != RS_WBGUARD) begin
                    we = 1'b1;
                    if (has_data) begin
                        w_data = rsp_data;
                        w_l2   = L2_DIRTY;
                    end
                    w_own = t_src_q;
                    if (!t_op_q) begin
                        w_dir   = MS_S;
                        w_shr   = bit_of(t_src_q) |
                                  ((rsp_type == RS_WB) ? '0 : bit_of(t_tgt_q));
                        t_gst_d = MS_S;
                    end else begin
                        w_dir   = MS_M;
                        w_shr   = '0;
                        t_gst_d = MS_M;
                    end
                    state_d = ST_GRANT;
                end
            end
            ST_INVWAIT: begin
                if (txn_rsp) begin
                    t_rem_d = pick_in;
                    if (!pick_found) begin
                        we      = 1'b1;
                        w_dir   = MS_M;
                        w_own   = t_src_q;
                        w_shr   = '0;
                        t_gst_d = MS_M;
                        state_d = ST_GRANT;
                    end else begin
                        t_tgt_d = pick_idx;
                        state_d = ST_INVREQ;
                    end
                end
            end
            ST_GRANT: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_ready = state_q == ST_IDLE && !rsp_valid;
        ra_idx    = (state_q == ST_IDLE) ? req_addr : t_idx_q;
        rb_idx    = rsp_addr;
        fwd_valid = 1'b0;
        fwd_type  = FW_MEMRD;
        fwd_dest  = t_tgt_q;
        fwd_addr  = t_idx_q;
        unique case (state_q)
            ST_MEMREQ: begin
                fwd_valid = 1'b1;
                fwd_dest  = '0;
            end
            ST_DGREQ: begin
                fwd_valid = 1'b1;
                fwd_type  = t_op_q ? FW_DGWR : FW_DGRD;
            end
            ST_INVREQ: begin
                fwd_valid = 1'b1;
                fwd_type  = FW_INV;
            end
            default: fwd_valid = 1'b0;
        endcase
        ack_valid = state_q == ST_GRANT;
        ack_dest  = t_src_q;
        ack_state = t_gst_q;
        ack_data  = ra_data;
    end

    AST_FWD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_valid && !fwd_ready |=> fwd_valid && $stable(fwd_type) &&
        $stable(fwd_dest) && $stable(fwd_addr)); // R12
    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |=> !ack_valid); // R9
    AST_NO_ACK_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !ack_valid || ack_dest == $past(req_src)); // R9
    AST_INV_NOT_SELF: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_valid && fwd_type == FW_INV |-> fwd_dest != t_src_q); // R7
    AST_DG_NOT_SELF: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_valid && (fwd_type == FW_DGRD || fwd_type == FW_DGWR) |-> fwd_dest != t_src_q); // R5
    AST_GRANT_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |-> ack_state != MS_I); // R2

endmodule

// File: rtl/mesi_dir_ctrl.sv
module mesi_dir_ctrl
    import mesi_dir_pkg::*;
#(
    parameter int NLINE  = 8,
    parameter int NCACHE = 4,
    parameter int DATA_W = 16,
    localparam int IDX_W = $clog2(NLINE),
    localparam int ID_W  = $clog2(NCACHE)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_op,
    input  logic [ID_W-1:0]   req_src,
    input  logic [IDX_W-1:0]  req_addr,
    output logic              fwd_valid,
    input  logic              fwd_ready,
    output logic [1:0]        fwd_type,
    output logic [ID_W-1:0]   fwd_dest,
    output logic [IDX_W-1:0]  fwd_addr,
    input  logic              rsp_valid,
    input  logic [1:0]        rsp_type,
    input  logic [ID_W-1:0]   rsp_src,
    input  logic [IDX_W-1:0]  rsp_addr,
    input  logic              rsp_dirty,
    input  logic [DATA_W-1:0] rsp_data,
    output logic              ack_valid,
    output logic [ID_W-1:0]   ack_dest,
    output logic [1:0]        ack_state,
    output logic [DATA_W-1:0] ack_data
);

    logic [IDX_W-1:0]  ra_idx, rb_idx, w_idx;
    l2_e               ra_l2, w_l2;
    mesi_e             ra_dir, rb_dir, w_dir, ack_st;
    logic [ID_W-1:0]   ra_own, rb_own, w_own;
    logic [NCACHE-1:0] ra_shr, w_shr;
    logic [DATA_W-1:0] ra_data, w_data;
    logic              we;
    fwd_e              fwd_t;

    mesi_dir_store #(.NLINE(NLINE), .NCACHE(NCACHE), .DATA_W(DATA_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .ra_idx(ra_idx), .ra_l2(ra_l2), .ra_dir(ra_dir), .ra_own(ra_own),
        .ra_shr(ra_shr), .ra_data(ra_data),
        .rb_idx(rb_idx), .rb_dir(rb_dir), .rb_own(rb_own),
        .we(we), .w_idx(w_idx), .w_l2(w_l2), .w_dir(w_dir), .w_own(w_own),
        .w_shr(w_shr), .w_data(w_data)
    );

    mesi_dir_fsm #(.NLINE(NLINE), .NCACHE(NCACHE), .DATA_W(DATA_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
        .req_src(req_src), .req_addr(req_addr),
        .fwd_valid(fwd_valid), .fwd_ready(fwd_ready), .fwd_type(fwd_t),
        .fwd_dest(fwd_dest), .fwd_addr(fwd_addr),
        .rsp_valid(rsp_valid), .rsp_type(rsp_e'(rsp_type)), .rsp_src(rsp_src),
        .rsp_addr(rsp_addr), .rsp_dirty(rsp_dirty), .rsp_data(rsp_data),
        .ack_valid(ack_valid), .ack_dest(ack_dest), .ack_state(ack_st),
        .ack_data(ack_data),
        .ra_idx(ra_idx), .ra_l2(ra_l2), .ra_dir(ra_dir), .ra_own(ra_own),
        .ra_shr(ra_shr), .ra_data(ra_data),
        .rb_idx(rb_idx), .rb_dir(rb_dir), .rb_own(rb_own),
        .we(we), .w_idx(w_idx), .w_l2(w_l2), .w_dir(w_dir), .w_own(w_own),
        .w_shr(w_shr), .w_data(w_data)
    );

    assign fwd_type  = fwd_t;
    assign ack_state = ack_st;

endmodule

// File: tb/mesi_dir_ctrl_bench.sv
module mesi_dir_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_op = 1'b0;
    logic [1:0]  req_src = '0;
    logic [2:0]  req_addr = '0;
    logic        fwd_ready = 1'b1;
    logic        rsp_valid = 1'b0, rsp_dirty = 1'b0;
    logic [1:0]  rsp_type = '0, rsp_src = '0;
    logic [2:0]  rsp_addr = '0;
    logic [15:0] rsp_data = '0;
    logic        req_ready, fwd_valid, ack_valid;
    logic [1:0]  fwd_type, fwd_dest, ack_dest, ack_state;
    logic [2:0]  fwd_addr;
    logic [15:0] ack_data;

    int checks = 0, fails = 0;
    bit done = 0;

    always #5 clk = ~clk;

    mesi_dir_ctrl u_mesi_dir_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
        .req_src(req_src), .req_addr(req_addr),
        .fwd_valid(fwd_valid), .fwd_ready(fwd_ready), .fwd_type(fwd_type),
        .fwd_dest(fwd_dest), .fwd_addr(fwd_addr),
        .rsp_valid(rsp_valid), .rsp_type(rsp_type), .rsp_src(rsp_src),
        .rsp_addr(rsp_addr), .rsp_dirty(rsp_dirty), .rsp_data(rsp_data),
        .ack_valid(ack_valid), .ack_dest(ack_dest), .ack_state(ack_state),
        .ack_data(ack_data)
    );

    typedef struct packed {
        logic        op;
        logic [1:0]  src;
        logic [2:0]  addr;
        logic [15:0] dgd;
        logic [1:0]  nfwd;
        logic [1:0]  ftyp;
        logic [1:0]  fdst;
        logic [1:0]  ast;
        logic [15:0] adat;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t TBL [NV] = '{
        '{1'b0, 2'd0, 3'd1, 16'h0000, 2'd1, 2'd0, 2'd0, 2'd2, 16'hA001, 4'd2},  // R2 miss load
        '{1'b0, 2'd1, 3'd1, 16'h0000, 2'd1, 2'd1, 2'd0, 2'd1, 16'hA001, 4'd5},  // R5 clean owner
        '{1'b0, 2'd2, 3'd1, 16'h0000, 2'd0, 2'd0, 2'd0, 2'd1, 16'hA001, 4'd4},  // R4 shared hit
        '{1'b1, 2'd1, 3'd1, 16'h0000, 2'd2, 2'd3, 2'd0, 2'd3, 16'hA001, 4'd7},  // R7 inv 0,2
        '{1'b0, 2'd3, 3'd1, 16'h1111, 2'd1, 2'd1, 2'd1, 2'd1, 16'h1111, 4'd5},  // R5 dirty owner
        '{1'b1, 2'd2, 3'd2, 16'h0000, 2'd1, 2'd0, 2'd0, 2'd3, 16'hA002, 4'd2},  // R2 miss store
        '{1'b1, 2'd3, 3'd2, 16'h2222, 2'd1, 2'd2, 2'd2, 2'd3, 16'h2222, 4'd6},  // R6
        '{1'b0, 2'd3, 3'd2, 16'h0000, 2'd0, 2'd0, 2'd0, 2'd3, 16'h2222, 4'd8},  // R8 owner load M
        '{1'b1, 2'd0, 3'd1, 16'h0000, 2'd2, 2'd3, 2'd1, 2'd3, 16'h1111, 4'd7},  // R7 inv 1,3
        '{1'b0, 2'd0, 3'd5, 16'h0000, 2'd1, 2'd0, 2'd0, 2'd2, 16'hA005, 4'd2},  // R2
        '{1'b1, 2'd0, 3'd5, 16'h0000, 2'd0, 2'd0, 2'd0, 2'd3, 16'hA005, 4'd8}   // R8 owner store
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_rsp(input logic [1:0] t, input logic [1:0] s, input logic [2:0] a,
                            input logic d, input logic [15:0] v);
        @(negedge clk);
        rsp_valid = 1'b1; rsp_type = t; rsp_src = s; rsp_addr = a; rsp_dirty = d; rsp_data = v;
        @(posedge clk); #1 rsp_valid = 1'b0;
    endtask

    task automatic run_req(input logic op, input logic [1:0] src, input logic [2:0] addr,
                           input logic [15:0] dgd, output int nf, output logic [1:0] ft,
                           output logic [1:0] fd, output bit got, output logic [1:0] ad,
                           output logic [1:0] as, output logic [15:0] dat);
        nf = 0; ft = '0; fd = '0; got = 0; ad = '0; as = '0; dat = '0;
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_src = src; req_addr = addr;
        @(posedge clk); #1 req_valid = 1'b0;
        for (int c = 0; c < 40 && !got; c++) begin
            @(negedge clk);
            if (ack_valid) begin
                got = 1; ad = ack_dest; as = ack_state; dat = ack_data;
            end else if (fwd_valid) begin
                logic [1:0] t;
                logic [15:0] v;
                logic d;
                if (nf == 0) begin ft = fwd_type; fd = fwd_dest; end
                nf++;
                t = (fwd_type == 2'd0) ? 2'd0 : 2'd1;
                v = (fwd_type == 2'd0) ? (16'hA000 | 16'(fwd_addr)) : dgd;
                d = (fwd_type == 2'd1 || fwd_type == 2'd2) && dgd != 16'h0;
                @(posedge clk); #1;
                rsp_valid = 1'b1; rsp_type = t; rsp_src = fwd_dest; rsp_addr = fwd_addr;
                rsp_dirty = d; rsp_data = v;
                @(posedge clk); #1 rsp_valid = 1'b0;
            end
        end
    endtask

    task automatic expect_grant(input string req, input logic op, input logic [1:0] src,
                                input logic [2:0] addr, input int enf,
                                input logic [1:0] eas, input logic [15:0] edat);
        int nf; logic [1:0] ft, fd, ad, as; logic [15:0] dat; bit got;
        run_req(op, src, addr, 16'h0, nf, ft, fd, got, ad, as, dat);
        check(nf == enf, req, nf, enf);
        check(got && ad == src && as == eas, req, as, eas);
        check(dat == edat, req, dat, edat);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(req_ready && !fwd_valid && !ack_valid, "R1 reset outputs",
              {req_ready, fwd_valid, ack_valid}, 3'b100);

        for (int i = 0; i < NV; i++) begin
            int nf; logic [1:0] ft, fd, ad, as; logic [15:0] dat; bit got;
            string tag;
            tag = $sformatf("R%0d vec%0d", TBL[i].rq, i);
            run_req(TBL[i].op, TBL[i].src, TBL[i].addr, TBL[i].dgd, nf, ft, fd, got, ad, as, dat);
            check(nf == int'(TBL[i].nfwd), tag, nf, TBL[i].nfwd);
            if (TBL[i].nfwd != 0) begin
                check(ft == TBL[i].ftyp, tag, ft, TBL[i].ftyp);
                check(fd == TBL[i].fdst, tag, fd, TBL[i].fdst);
            end
            check(got && ad == TBL[i].src, tag, ad, TBL[i].src);
            check(as == TBL[i].ast, tag, as, TBL[i].ast);
            check(dat == TBL[i].adat, tag, dat, TBL[i].adat);
        end

        // R10 R3: idle writeback from owner 3 of line 2, then served from slice copy
        send_rsp(2'd3, 2'd3, 3'd2, 1'b0, 16'h3333);
        expect_grant("R10 R3 wb then load", 1'b0, 2'd1, 3'd2, 0, 2'd2, 16'h3333);
        // R10: writeback from non-owner 2 is ignored
        send_rsp(2'd3, 2'd2, 3'd2, 1'b0, 16'h9999);
        expect_grant("R10 stale wb ignored", 1'b0, 2'd1, 3'd2, 0, 2'd2, 16'h3333);

        // R11 R9: guarded writeback race, with a stray writeback to another line
        @(negedge clk);
        req_valid = 1'b1; req_op = 1'b1; req_src = 2'd0; req_addr = 3'd2;
        @(posedge clk); #1 req_valid = 1'b0;
        @(negedge clk);
        check(fwd_valid && fwd_type == 2'd2 && fwd_dest == 2'd1, "R6 write downgrade",
              {fwd_valid, fwd_type, fwd_dest}, {1'b1, 2'd2, 2'd1});
        @(posedge clk); #1;
        send_rsp(2'd2, 2'd1, 3'd2, 1'b0, 16'h0);
        send_rsp(2'd3, 2'd0, 3'd1, 1'b0, 16'h5555);
        @(negedge clk);
        check(!ack_valid, "R11 guard does not complete", ack_valid, 0);
        check(!req_ready, "R9 blocked while pending", req_ready, 0);
        send_rsp(2'd3, 2'd1, 3'd2, 1'b0, 16'h4444);
        @(negedge clk);
        check(ack_valid && ack_dest == 2'd0 && ack_state == 2'd3, "R11 grant after wb",
              {ack_valid, ack_dest, ack_state}, {1'b1, 2'd0, 2'd3});
        check(ack_data == 16'h4444, "R11 wb data", ack_data, 16'h4444);
        @(posedge clk); #1;
        @(negedge clk);
        check(!ack_valid, "R9 ack lasts one cycle", ack_valid, 0);
        expect_grant("R10 wb during pending", 1'b0, 2'd2, 3'd1, 0, 2'd2, 16'h5555);

        // R3 store served from slice after owner writeback
        send_rsp(2'd3, 2'd2, 3'd1, 1'b0, 16'h6666);
        expect_grant("R3 store from copy", 1'b1, 2'd1, 3'd1, 0, 2'd3, 16'h6666);

        // R12: forward held while stalled
        fwd_ready = 1'b0;
        @(negedge clk);
        req_valid = 1'b1; req_op = 1'b0; req_src = 2'd2; req_addr = 3'd6;
        @(posedge clk); #1 req_valid = 1'b0;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check(fwd_valid && fwd_type == 2'd0 && fwd_addr == 3'd6, "R12 stall hold",
                  {fwd_valid, fwd_type, fwd_addr}, {1'b1, 2'd0, 3'd6});
        end
        fwd_ready = 1'b1;
        @(posedge clk); #1;
        send_rsp(2'd0, 2'd0, 3'd6, 1'b0, 16'hA006);
        @(negedge clk);
        check(ack_valid && ack_state == 2'd2 && ack_data == 16'hA006, "R2 after stall",
              ack_data, 16'hA006);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule